// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the state changes a processor core makes when it enters a trap, once another unit has already chosen which trap to take. A one-cycle start strobe latches the current processor status word, the trap base address, the two program counters, the pending-annul flag and the reset-trap flag. The block then walks through four fixed steps, one per clock cycle.

First it rotates the register window pointer down by one and writes the status word back with traps disabled. Next it saves the return addresses into registers 17 and 18 of the newly selected window through a register-file write port. Finally it raises supervisor mode and points the program counters at the trap vector, or at the fixed reset addresses.

Each state update leaves the block as a write-enable strobe paired with its data. The surrounding core applies that update to its own registers, and to its annul and reset-trap flags when asked to clear them.

Top module: `trap_entry_seq`

## Requirements
- R1: The new window pointer is (CWP - 1) modulo NWINDOWS, with CWP in status bits [4:0]. This holds for every 5-bit input value, including values at or above NWINDOWS. The default NWINDOWS is 8.
- R2: In the first cycle after an accepted start, psr_we_o is high. psr_o equals the captured status word with bits [4:0] set to the new window pointer, bit 5 (trap enable) cleared, and bit 6 (previous supervisor) set to the old bit 7 (supervisor). All other bits are unchanged.
- R3: In the second cycle, rf_we_o is high with rf_win_o set to the new window pointer and rf_idx_o set to 17. rf_data_o carries PC when annul is clear and nPC when annul is set.
- R4: In the third cycle, rf_we_o is high with the same window and rf_idx_o set to 18. rf_data_o carries nPC when annul is clear and nPC+4 when annul is set. annul_clr_o is high in this cycle exactly when the captured annul flag is set, and low at all other times.
- R5: In the fourth cycle, psr_we_o is high again and psr_o equals the R2 value with bit 7 (supervisor) set to 1.
- R6: For a normal trap, the fourth cycle raises pc_we_o with pc_o equal to the trap base and npc_o equal to the trap base + 4.
- R7: For a reset trap, the fourth cycle raises pc_we_o with pc_o = 0 and npc_o = 4. reset_trap_clr_o is high in that cycle only, and never during a normal trap.
- R8: done_o is high only in the fourth cycle. busy_o is high for exactly the four step cycles and low in the cycle that follows.
- R9: start_i is accepted only while busy_o is low. While a sequence runs, changes on start_i and on every data input have no effect on any output.
- R10: After reset, busy_o, done_o and every write-enable and clear strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin trap entry (accepted when idle) |
| psr_i | input | 32 | Current processor status word |
| tbr_i | input | 32 | Trap vector address |
| pc_i | input | 32 | Current program counter |
| npc_i | input | 32 | Next program counter |
| annul_i | input | 1 | Pending annul of the next instruction |
| reset_trap_i | input | 1 | Trap being entered is a reset |
| rf_we_o | output | 1 | Register-file write enable |
| rf_win_o | output | 5 | Register-file target window |
| rf_idx_o | output | 5 | Register index within the window |
| rf_data_o | output | 32 | Register-file write data |
| psr_we_o | output | 1 | Status word write enable |
| psr_o | output | 32 | Status word write data |
| pc_we_o | output | 1 | Program counter pair write enable |
| pc_o | output | 32 | New program counter |
| npc_o | output | 32 | New next program counter |
| annul_clr_o | output | 1 | Clear the annul flag |
| reset_trap_clr_o | output | 1 | Clear the reset-trap flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final step of the sequence |

## Verification
A wrong step counter appears at once as a write strobe that is missing, doubled or out of order, within the four cycles after start. A fault in the capture registers or the window arithmetic shows up as a wrong window number on the first status write and on both register saves. A sweep of all 32 window-pointer values, crossed with annul, reset and the supervisor bit, exposes any slip in the modulo wrap or in the save selection on the very sequence that triggers it. Inputs are scrambled and start is held high while each sequence runs, so any leak of live inputs into the outputs, or any restart, appears within the same sequence.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int XLEN   = 32;
  localparam int CWP_W  = 5;
  localparam int IDX_W  = 5;
  // status word field positions decoded by the core
  localparam int PSR_ET = 5;
  localparam int PSR_PS = 6;
  localparam int PSR_S  = 7;
  localparam logic [IDX_W-1:0] SAVE_PC_IDX  = IDX_W'(17);
  localparam logic [IDX_W-1:0] SAVE_NPC_IDX = IDX_W'(18);
  localparam logic [XLEN-1:0]  RST_PC       = '0;
  localparam logic [XLEN-1:0]  INSN_BYTES   = XLEN'(4);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PSR  = 3'd1,
    ST_R17  = 3'd2,
    ST_R18  = 3'd3,
    ST_VEC  = 3'd4
  } step_e;

  typedef struct packed {
    logic [XLEN-1:0] psr;
    logic [XLEN-1:0] tbr;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] npc;
    logic            annul;
    logic            rst_trap;
  } trap_ctx_t;
endpackage

// File: rtl/trap_psr_upd.sv
module trap_psr_upd
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8
) (
  input  logic [XLEN-1:0]  psr_i,
  output logic [CWP_W-1:0] cwp_new_o,
  output logic [XLEN-1:0]  psr_trap_o,
  output logic [XLEN-1:0]  psr_sup_o
);
  localparam bit POW2 = (NWINDOWS & (NWINDOWS - 1)) == 0;

  logic [CWP_W-1:0] cwp_old;
  assign cwp_old = psr_i[CWP_W-1:0];

  generate
    if (POW2) begin : g_mask
      localparam logic [CWP_W-1:0] MASK = CWP_W'(NWINDOWS - 1);
      assign cwp_new_o = (cwp_old - CWP_W'(1)) & MASK;
    end else begin : g_mod
      localparam int unsigned NW = NWINDOWS;
      int unsigned tmp;
      always_comb begin
        tmp       = (32'(cwp_old) + NW - 32'd1) % NW;
        cwp_new_o = tmp[CWP_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    psr_trap_o                = psr_i;
    psr_trap_o[CWP_W-1:0]     = cwp_new_o;
    psr_trap_o[PSR_ET]        = 1'b0;
    psr_trap_o[PSR_PS]        = psr_i[PSR_S];
    psr_sup_o                 = psr_trap_o;
    psr_sup_o[PSR_S]          = 1'b1;
  end
endmodule

// File: rtl/trap_save_sel.sv
module trap_save_sel
  import trap_entry_pkg::*;
(
  input  logic            annul_i,
  input  logic            second_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [XLEN-1:0]  data_o
);
  logic [XLEN-1:0] first_val, second_val;

  // annulled slot: return resumes after the skipped instruction
  assign first_val  = annul_i ? npc_i : pc_i;
  assign second_val = annul_i ? npc_i + INSN_BYTES : npc_i;

  assign idx_o  = second_i ? SAVE_NPC_IDX : SAVE_PC_IDX;
  assign data_o = second_i ? second_val : first_val;
endmodule

// File: rtl/trap_vec_sel.sv
module trap_vec_sel
  import trap_entry_pkg::*;
(
  input  logic            rst_trap_i,
  input  logic [XLEN-1:0] tbr_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o
);
  logic [XLEN-1:0] base;
  assign base  = rst_trap_i ? RST_PC : tbr_i;
  assign pc_o  = base;
  assign npc_o = base + INSN_BYTES;
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      psr_i,
  input  logic [31:0]      tbr_i,
  input  logic [31:0]      pc_i,
  input  logic [31:0]      npc_i,
  input  logic             annul_i,
  input  logic             reset_trap_i,
  output logic             rf_we_o,
  output logic [4:0]       rf_win_o,
  output logic [4:0]       rf_idx_o,
  output logic [31:0]      rf_data_o,
  output logic             psr_we_o,
  output logic [31:0]      psr_o,
  output logic             pc_we_o,
  output logic [31:0]      pc_o,
  output logic [31:0]      npc_o,
  output logic             annul_clr_o,
  output logic             reset_trap_clr_o,
  output logic             busy_o,
  output logic             done_o
);
  step_e     state_q, state_d;
  trap_ctx_t ctx_q;
  logic      accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_PSR;
      ST_PSR:  state_d = ST_R17;
      ST_R17:  state_d = ST_R18;
      ST_R18:  state_d = ST_VEC;
      ST_VEC:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ctx_q.psr      <= psr_i;
        ctx_q.tbr      <= tbr_i;
        ctx_q.pc       <= pc_i;
        ctx_q.npc      <= npc_i;
        ctx_q.annul    <= annul_i;
        ctx_q.rst_trap <= reset_trap_i;
      end
    end
  end

  logic [CWP_W-1:0] cwp_new;
  logic [XLEN-1:0]  psr_trap, psr_sup;

  trap_psr_upd #(.NWINDOWS(NWINDOWS)) u_psr (
    .psr_i      (ctx_q.psr),
    .cwp_new_o  (cwp_new),
    .psr_trap_o (psr_trap),
    .psr_sup_o  (psr_sup)
  );

  trap_save_sel u_save (
    .annul_i  (ctx_q.annul),
    .second_i (state_q == ST_R18),
    .pc_i     (ctx_q.pc),
    .npc_i    (ctx_q.npc),
    .idx_o    (rf_idx_o),
    .data_o   (rf_data_o)
  );

  trap_vec_sel u_vec (
    .rst_trap_i (ctx_q.rst_trap),
    .tbr_i      (ctx_q.tbr),
    .pc_o       (pc_o),
    .npc_o      (npc_o)
  );

  assign busy_o           = state_q != ST_IDLE;
  assign rf_we_o          = (state_q == ST_R17) || (state_q == ST_R18);
  assign rf_win_o         = cwp_new;
  assign psr_we_o         = (state_q == ST_PSR) || (state_q == ST_VEC);
  assign psr_o            = (state_q == ST_VEC) ? psr_sup : psr_trap;
  assign pc_we_o          = state_q == ST_VEC;
  assign done_o           = state_q == ST_VEC;
  assign annul_clr_o      = (state_q == ST_R18) && ctx_q.annul;
  assign reset_trap_clr_o = (state_q == ST_VEC) && ctx_q.rst_trap;

  // window targeted by saves stays inside the implemented range
  p_win_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> ({1'b0, rf_win_o} < (CWP_W+1)'(NWINDOWS)));

  p_r18_after_r17_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_idx_o == SAVE_PC_IDX) |=> (rf_we_o && rf_idx_o == SAVE_NPC_IDX && $stable(rf_win_o)));

  p_sup_on_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (psr_we_o && psr_o[PSR_S] && !psr_o[PSR_ET]));

  p_vec_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> (npc_o == pc_o + INSN_BYTES));

  p_clr_only_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_trap_clr_o |-> (done_o && pc_o == RST_PC));

  p_done_after_r18_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_idx_o == SAVE_NPC_IDX) |=> (done_o && pc_we_o));

  p_idle_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o && !$rose(psr_we_o && !done_o)));

  p_strobes_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, psr_we_o && !done_o, done_o}));
endmodule

// File: tb/tb_trap_entry_seq.sv
`timescale 1ns/1ps
module tb_trap_entry_seq;
  localparam int NW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, annul = 1'b0, rtrap = 1'b0;
  logic [31:0] psr = '0, tbr = '0, pc = '0, npc = '0;
  logic rf_we, psr_we, pc_we, annul_clr, rt_clr, busy, done;
  logic [4:0] rf_win, rf_idx;
  logic [31:0] rf_data, psr_w, pc_w, npc_w;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  trap_entry_seq #(.NWINDOWS(NW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .psr_i(psr), .tbr_i(tbr),
    .pc_i(pc), .npc_i(npc), .annul_i(annul), .reset_trap_i(rtrap),
    .rf_we_o(rf_we), .rf_win_o(rf_win), .rf_idx_o(rf_idx), .rf_data_o(rf_data),
    .psr_we_o(psr_we), .psr_o(psr_w), .pc_we_o(pc_we), .pc_o(pc_w), .npc_o(npc_w),
    .annul_clr_o(annul_clr), .reset_trap_clr_o(rt_clr), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble();
    psr = ~psr; tbr = tbr ^ 32'h5a5a_5000; pc = ~pc; npc = npc + 32'h100;
    annul = ~annul; rtrap = ~rtrap;
  endtask

  task automatic run(input logic [31:0] p, input logic [31:0] t, input logic [31:0] a,
                     input logic [31:0] n, input logic an, input logic rt);
    logic [4:0] ncwp;
    logic [31:0] e_psr;
    ncwp  = 5'((p[4:0] + NW - 1) % NW);
    e_psr = p;
    e_psr[4:0] = ncwp; e_psr[5] = 1'b0; e_psr[6] = p[7];
    @(negedge clk);
    psr = p; tbr = t; pc = a; npc = n; annul = an; rtrap = rt; start = 1'b1;
    @(negedge clk);
    chk("R2 psr_we", {31'd0, psr_we}, 32'd1);
    chk("R2 psr", psr_w, e_psr);
    chk("R8 busy", {31'd0, busy}, 32'd1);
    scramble();  // R9: start held high, inputs change
    @(negedge clk);
    chk("R3 we/idx", {26'd0, rf_we, rf_idx}, {26'd0, 1'b1, 5'd17});
    chk("R1 win", {27'd0, rf_win}, {27'd0, ncwp});
    chk("R3 data", rf_data, an ? n : a);
    scramble();
    @(negedge clk);
    chk("R4 we/idx", {26'd0, rf_we, rf_idx}, {26'd0, 1'b1, 5'd18});
    chk("R1 win18", {27'd0, rf_win}, {27'd0, ncwp});
    chk("R4 data", rf_data, an ? n + 32'd4 : n);
    chk("R4 annul_clr", {31'd0, annul_clr}, {31'd0, an});
    chk("R8 no done early", {31'd0, done}, 32'd0);
    scramble();
    @(negedge clk);
    chk("R8 done", {31'd0, done}, 32'd1);
    chk("R5 psr", psr_w, e_psr | 32'h80);
    chk("R5 psr_we", {31'd0, psr_we}, 32'd1);
    chk(rt ? "R7 pc" : "R6 pc", pc_w, rt ? 32'd0 : t);
    chk(rt ? "R7 npc" : "R6 npc", npc_w, rt ? 32'd4 : t + 32'd4);
    chk("R7 rt_clr", {31'd0, rt_clr}, {31'd0, rt});
    chk("R6 pc_we", {31'd0, pc_we}, 32'd1);
    chk("R4 annul_clr low", {31'd0, annul_clr}, 32'd0);
    start = 1'b0;
    @(negedge clk);
    chk("R8 idle", {25'd0, busy, done, rf_we, psr_we, pc_we, annul_clr, rt_clr}, 32'd0);
    chk("R9 no restart", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset strobes", {25'd0, busy, done, rf_we, psr_we, pc_we, annul_clr, rt_clr}, 32'd0);
    start = 1'b1;
    @(negedge clk);
    chk("R10 start held in reset", {31'd0, busy}, 32'd0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", {31'd0, busy}, 32'd0);
    for (int c = 0; c < 32; c++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] p;
        p = {8'hA5 ^ 8'(c), 16'h3C00 | 16'(m), 8'(c)} ;
        p[7] = m[0];
        p[5] = 1'b1;
        p[6] = ~m[0];
        run(p, 32'h4000_0000 + 32'(c) * 32'h1000 + 32'(m) * 32'h10,
            32'h0100_0000 + 32'(c * 64 + m * 8), 32'h0100_0004 + 32'(c * 64 + m * 8) + 32'(m) * 32'h20,
            m[1], m[2]);
      end
    end
    run(32'hFFFF_FF40, 32'hFFFF_FFF0, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1'b1, 1'b0);
    run(32'h0000_0000, 32'h0000_0000, 32'h0, 32'h4, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule